// File: doc/BRIEF.md
# Serial Command-Decoding DAC Register Interface

This block is the digital front end of a converter. A host frames a serial bit stream with an active-low select line. While the frame is open, each rising edge of the serial clock pushes one bit into a 32-bit shift register. The bit pushed out of the far end of that register is driven on a serial output. Several devices can therefore be chained, sharing clock and select, with each serial output feeding the next device's serial input.

When the select line rises, the block reads a 4-bit command and a 16-bit data word from fixed positions in the shift register. The command drives a double-buffered path:

- a holding (input) buffer,
- a DAC buffer whose value is the converter code output,
- a 3-bit span register that chooses the converter's output range.

A 24-bit frame and a 32-bit frame (with 8 leading filler bits) decode identically. An active-low zero input clears every register.

The serial pins are asynchronous to the block's clock. They are oversampled through synchronizers, and all state lives in the `clk` domain.

Top module: `serial_dac_ctrl`

## Requirements
- R1: While `sel_n` is high, serial clock edges are ignored: `ser_out` does not change and the shift register contents are preserved for the next frame.
- R2: On the `sel_n` rising edge the command is shift-register bits [23:20] and the data word is bits [15:0]. Frames are sent MSB first as command(4), filler(4), data(16), optionally preceded by 8 filler bits. 24- and 32-bit frames give the same result.
- R3: Command 4'b0000 copies the data word into the holding buffer only; `dac_code` is unchanged.
- R4: Command 4'b0001 copies the holding buffer into the DAC buffer (`dac_code`).
- R5: Command 4'b0010 copies the data word into both buffers.
- R6: Commands 4'b1000 to 4'b1101 set `span_code` to the command's low three bits (0..5) and copy the data word into both buffers. `span_code` never exceeds 5.
- R7: Command 4'b1111 and the reserved codes 4'b0011 to 4'b0111 and 4'b1110 change no register: the holding buffer, `dac_code` and `span_code` keep their values.
- R8: A bit shifted in appears on `ser_out` after 32 further serial clock rising edges. `ser_out` changes only on a serial clock rising edge inside a frame.
- R9: After reset, `dac_code` is 0, `span_code` is 0 and `ser_out` is 0.
- R10: While `zero_n` is low, the holding buffer, the DAC buffer, the span code and the shift register are all zero. A following 4'b0001 command keeps `dac_code` at 0.
- R11: `dac_code` and `span_code` change only when a frame ends or when cleared, never during shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial clock; data is captured on its rising edge |
| ser_in | input | 1 | Serial data input |
| sel_n | input | 1 | Active-low frame select; its rising edge executes the command |
| zero_n | input | 1 | Active-low clear of all registers |
| ser_out | output | 1 | Serial data output for daisy-chaining |
| dac_code | output | 16 | DAC buffer contents, the converter code |
| span_code | output | 3 | Output range: 0 = 0..5 V, 1 = 0..10 V, 2 = ±5 V, 3 = ±10 V, 4 = ±2.5 V, 5 = -2.5..7.5 V |

## Verification
A corrupted holding buffer stays hidden until a 4'b0001 transfer exposes it on `dac_code`. For that reason, every command in the sweep is followed by a transfer frame that reads the buffer back. A wrong shift-register bit shows on `ser_out` exactly 32 serial edges after the bit entered; the chained-frame check compares every output bit of a second frame with the first frame. A decode fault shows on `dac_code` or `span_code` a few clock cycles after the select line rises. A frame that leaks into the outputs early is caught by sampling `dac_code` before the frame closes.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;
  localparam int OP_LSB  = 20;
  localparam int RANGE_W = 3;

  typedef enum logic [RANGE_W-1:0] {
    RNG_UNI5  = 3'd0,
    RNG_UNI10 = 3'd1,
    RNG_BI5   = 3'd2,
    RNG_BI10  = 3'd3,
    RNG_BI2P5 = 3'd4,
    RNG_OFS   = 3'd5
  } range_e;

  typedef struct packed {
    logic   hold_wr;   // data word -> holding buffer
    logic   out_wr;    // data word -> DAC buffer
    logic   xfer;      // holding buffer -> DAC buffer
    logic   range_wr;  // load range register
    range_e range;
  } action_t;

  function automatic action_t decode_op(input logic [OP_W-1:0] op);
    action_t a;
    a = '{hold_wr: 1'b0, out_wr: 1'b0, xfer: 1'b0, range_wr: 1'b0, range: RNG_UNI5};
    case (op)
      4'h0: a.hold_wr = 1'b1;
      4'h1: a.xfer    = 1'b1;
      4'h2: begin
        a.hold_wr = 1'b1;
        a.out_wr  = 1'b1;
      end
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
        a.hold_wr  = 1'b1;
        a.out_wr   = 1'b1;
        a.range_wr = 1'b1;
        a.range    = range_e'(op[2:0]);
      end
      default: a = a;  // no-op and reserved codes
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int              WIDTH  = 4,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] RVAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = din;
      end else begin : g_rest
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RVAL;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
  import sdac_pkg::*;
#(
  parameter int LEN    = FRAME_W,
  parameter int DW     = DATA_W,
  parameter int OW     = OP_W,
  parameter int OP_POS = OP_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic          bit_out,
  output logic [OW-1:0] op_o,
  output logic [DW-1:0] word_o
);

  logic [LEN-1:0] sr_q, sr_d;
  logic           out_q, out_d;

  always_comb begin
    sr_d  = sr_q;
    out_d = out_q;
    if (clr) begin
      sr_d  = '0;
      out_d = 1'b0;
    end else if (shift_en) begin
      sr_d  = {sr_q[LEN-2:0], bit_in};
      out_d = sr_q[LEN-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      out_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      out_q <= out_d;
    end
  end

  assign bit_out = out_q;
  assign op_o    = sr_q[OP_POS +: OW];
  assign word_o  = sr_q[DW-1:0];

endmodule

// File: rtl/sdac_exec.sv
module sdac_exec
  import sdac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OP_W,
  parameter int RW = RANGE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [OW-1:0] op,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] out_code,
  output logic [RW-1:0] range_code
);

  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] out_q, out_d;
  range_e        rng_q, rng_d;
  action_t       act;

  always_comb begin
    act    = decode_op(op);
    hold_d = hold_q;
    out_d  = out_q;
    rng_d  = rng_q;
    if (clr) begin
      hold_d = '0;
      out_d  = '0;
      rng_d  = RNG_UNI5;
    end else if (run) begin
      if (act.hold_wr)  hold_d = word;
      if (act.out_wr)   out_d  = word;
      else if (act.xfer) out_d = hold_q;
      if (act.range_wr) rng_d  = act.range;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
      rng_q  <= RNG_UNI5;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
      rng_q  <= rng_d;
    end
  end

  assign out_code   = out_q;
  assign range_code = RW'(rng_q);

endmodule

// File: rtl/serial_dac_ctrl.sv
module serial_dac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_in,
  input  logic               sel_n,
  input  logic               zero_n,
  output logic               ser_out,
  output logic [DATA_W-1:0]  dac_code,
  output logic [RANGE_W-1:0] span_code
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // pin synchronizers: {zero_n, sel_n, ser_in, ser_clk}
  logic [3:0] pins_sync;
  sdac_sync #(
    .WIDTH (4),
    .STAGES(SYNC_STAGES),
    .RVAL  (4'b1100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  ({zero_n, sel_n, ser_in, ser_clk}),
    .dout (pins_sync)
  );

  logic sck_lvl, din_lvl, cs_level, clr_active;
  assign sck_lvl    = pins_sync[0];
  assign din_lvl    = pins_sync[1];
  assign cs_level   = pins_sync[2];
  assign clr_active = ~pins_sync[3];

  // edge detection
  logic sck_prev_q, cs_prev_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_lvl;
      cs_prev_q  <= cs_level;
    end
  end

  logic shift_en, exec_pulse;
  assign shift_en   = sck_lvl & ~sck_prev_q & ~cs_level;
  assign exec_pulse = cs_level & ~cs_prev_q;

  logic [OP_W-1:0]   cmd_w;
  logic [DATA_W-1:0] data_w;

  sdac_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr_active),
    .shift_en(shift_en),
    .bit_in  (din_lvl),
    .bit_out (ser_out),
    .op_o    (cmd_w),
    .word_o  (data_w)
  );

  sdac_exec u_exec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (clr_active),
    .run       (exec_pulse),
    .op        (cmd_w),
    .word      (data_w),
    .out_code  (dac_code),
    .range_code(span_code)
  );

endmodule

// File: rtl/serial_dac_ctrl_checker.sv
module serial_dac_ctrl_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        exec_pulse,
  input logic        shift_en,
  input logic        cs_level,
  input logic        clr_active,
  input logic [3:0]  cmd_w,
  input logic [15:0] data_w,
  input logic        ser_out,
  input logic [15:0] dac_code,
  input logic [2:0]  span_code
);

  logic quiet_cmd;
  assign quiet_cmd = (cmd_w == 4'hF) || (cmd_w == 4'hE) ||
                     (cmd_w >= 4'h3 && cmd_w <= 4'h7);

  p_span_legal_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    span_code <= 3'd5);

  p_span_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_pulse && !clr_active && cmd_w[3] && cmd_w[2:0] <= 3'd5)
    |=> (span_code == $past(cmd_w[2:0]) && dac_code == $past(data_w)));

  p_quiet_cmd_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_pulse && !clr_active && quiet_cmd)
    |=> ($stable(dac_code) && $stable(span_code)));

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_active |=> (dac_code == 16'd0 && span_code == 3'd0 && ser_out == 1'b0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!exec_pulse && !clr_active) |=> ($stable(dac_code) && $stable(span_code)));

  p_out_edge_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!shift_en && !clr_active) |=> $stable(ser_out));

  p_sel_high_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_level && !clr_active) |=> $stable(ser_out));

endmodule

bind serial_dac_ctrl serial_dac_ctrl_checker u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .exec_pulse(exec_pulse),
  .shift_en  (shift_en),
  .cs_level  (cs_level),
  .clr_active(clr_active),
  .cmd_w     (cmd_w),
  .data_w    (data_w),
  .ser_out   (ser_out),
  .dac_code  (dac_code),
  .span_code (span_code)
);

// File: tb/serial_dac_ctrl_test.sv
module serial_dac_ctrl_test;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n, ser_clk, ser_in, sel_n, zero_n;
  logic        ser_out;
  logic [15:0] dac_code;
  logic [2:0]  span_code;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] m_hold, m_dac;
  logic [2:0]  m_span;

  always #4 clk = ~clk;

  serial_dac_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_in   (ser_in),
    .sel_n    (sel_n),
    .zero_n   (zero_n),
    .ser_out  (ser_out),
    .dac_code (dac_code),
    .span_code(span_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model(input logic [3:0] op, input logic [15:0] d);
    case (op)
      4'h0: m_hold = d;
      4'h1: m_dac = m_hold;
      4'h2: begin m_hold = d; m_dac = d; end
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
        m_hold = d; m_dac = d; m_span = op[2:0];
      end
      default: ;
    endcase
  endtask

  // sends one frame; when chain_chk is set, compares ser_out with ref_word
  task automatic send(input logic [3:0] op, input logic [15:0] d, input bit longf,
                      input bit chain_chk, input logic [31:0] ref_word,
                      output logic [31:0] sent);
    int n;
    logic [15:0] dac_before;
    n    = longf ? 32 : 24;
    sent = {8'hC3, op, 4'hA, d};
    dac_before = dac_code;
    sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      ser_in = sent[n-1-i];
      wait_clk(HALF);
      ser_clk = 1'b1;
      wait_clk(HALF);
      if (chain_chk) chk("R8 chained ser_out", {31'd0, ser_out}, {31'd0, ref_word[31-i]});
      ser_clk = 1'b0;
    end
    chk("R11 dac_code steady while shifting", {16'd0, dac_code}, {16'd0, dac_before});
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(10);
    model(op, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] fa, fb, junk;
    logic [15:0] d;
    rst_n = 1'b0; ser_clk = 1'b0; ser_in = 1'b0; sel_n = 1'b1; zero_n = 1'b1;
    m_hold = '0; m_dac = '0; m_span = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(8);

    // R9 reset state
    chk("R9 dac_code after reset", {16'd0, dac_code}, 32'd0);
    chk("R9 span_code after reset", {29'd0, span_code}, 32'd0);
    chk("R9 ser_out after reset", {31'd0, ser_out}, 32'd0);

    // R2..R7 sweep over every command, both frame lengths
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 16; c++) begin
        d = 16'(c * 16'h1111) ^ (p == 0 ? 16'hA5C3 : 16'h3C5A);
        send(4'(c), d, ((c + p) % 2) == 1, 1'b0, 32'd0, junk);
        chk($sformatf("R2-cmd%0h R3 R4 R5 R6 R7 dac_code", c), {16'd0, dac_code}, {16'd0, m_dac});
        chk($sformatf("R6 R7 span_code cmd%0h", c), {29'd0, span_code}, {29'd0, m_span});
        // read the holding buffer back through a transfer (R7 R3)
        send(4'h1, 16'hFFFF, (p == 1), 1'b0, 32'd0, junk);
        chk($sformatf("R4 R7 holding buffer after cmd%0h", c), {16'd0, dac_code}, {16'd0, m_hold});
      end
    end

    // R1 / R8 daisy chain: second frame pushes the first out bit by bit
    send(4'hF, 16'h96E1, 1'b1, 1'b0, 32'd0, fa);
    for (int k = 0; k < 5; k++) begin
      logic prev;
      prev = ser_out;
      ser_in = k[0];
      wait_clk(HALF); ser_clk = 1'b1;
      wait_clk(HALF); ser_clk = 1'b0;
      chk("R1 ser_out ignores ser_clk while sel_n high", {31'd0, ser_out}, {31'd0, prev});
    end
    send(4'hE, 16'h5A0F, 1'b1, 1'b1, fa, fb);
    chk("R7 reserved leaves dac_code", {16'd0, dac_code}, {16'd0, m_dac});

    // R10 clear, then transfer keeps zero
    send(4'hB, 16'hBEEF, 1'b0, 1'b0, 32'd0, junk);
    chk("R6 span 3 load", {29'd0, span_code}, 32'd3);
    zero_n = 1'b0;
    wait_clk(8);
    chk("R10 dac_code cleared", {16'd0, dac_code}, 32'd0);
    chk("R10 span_code cleared", {29'd0, span_code}, 32'd0);
    chk("R10 ser_out cleared", {31'd0, ser_out}, 32'd0);
    zero_n = 1'b1;
    wait_clk(6);
    m_hold = '0; m_dac = '0; m_span = '0;
    // transfer command with only 24 bits; upper bits zero after clear
    send(4'h1, 16'h1234, 1'b0, 1'b0, 32'd0, junk);
    chk("R10 transfer after clear keeps zero", {16'd0, dac_code}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule